// File: doc/BRIEF.md
# Dual-Port Word Memory with Collision Arbitration

This block is a clocked model of a word memory with two independent access ports, a left one and a right one. Each port has an active-low select, an active-low write strobe, an active-low read enable, two active-low byte-lane enables, a 14-bit address and separate write and read data buses. Both ports can touch any word in the same cycle. Writes go only to the byte lanes that are enabled.

When both ports are selected at the same address in the same cycle, an arbiter chooses one of them. The port that was already at that word on the previous cycle wins. A fixed tie-break favours the left port. The losing port sees a busy flag, and its write is held off for as long as the flag stays up. A strap input sets the mode. In primary mode the flags are computed locally and driven out. In secondary mode the flags come in from a primary device, so several devices can be placed side by side to build a wider word, and the local busy outputs stay low.

The array depth is a parameter. The default keeps 2K words so the model stays small. Setting `STORE_AW` to 14 gives the full 16K words, and the low `STORE_AW` address bits then pick the word.

Top module: `dpram_arb_top`

## Requirements
- R1: While `rst_n` is low, both busy outputs are 0 whatever the port inputs are. Both read data registers reset to 0.
- R2: A write happens at the rising clock edge when the port has `cs_n`=0 and `we_n`=0 and is not busy. Only the enabled lanes change: `ub_n`=0 enables bits 15:8 and `lb_n`=0 enables bits 7:0.
- R3: A read is captured at the rising edge when the port has `cs_n`=0, `we_n`=1 and `oe_n`=0. Lanes whose enable is 1 read as 0. At all other times the read data holds its value. A word written at one edge is returned by a read captured at the next edge.
- R4: In primary mode, a busy flag is raised toward one port exactly when both ports have `cs_n`=0 and equal addresses. It drops when the addresses differ or either `cs_n` is 1. The two flags are never both 1.
- R5: A port that was selected at the contested address on the previous cycle wins over a port that has just arrived there. The winner keeps the grant for as long as the match continues.
- R6: If both ports arrive at the same address in the same cycle, the left port wins and `busy_r_o` is raised.
- R7: A write from a port whose effective busy is 1 does not change the array.
- R8: A write that is held on the losing port is committed on the first clock edge at which its busy is 0, provided the port still presents it.
- R9: A read on a port whose busy is 1 still returns data. That data includes the winner's write from the previous edge.
- R10: In secondary mode (`primary`=0), both busy outputs are 0, and `busy_l_i`/`busy_r_i` block writes on their ports. In primary mode those inputs have no effect.
- R11: The two ports can write different addresses in the same cycle, and both writes take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| primary | input | 1 | 1: busy computed locally; 0: busy taken from inputs |
| l_cs_n | input | 1 | Left port select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read enable, active low |
| l_ub_n | input | 1 | Left upper lane enable, active low |
| l_lb_n | input | 1 | Left lower lane enable, active low |
| l_addr | input | 14 | Left address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data |
| busy_l_i | input | 1 | Busy toward left, from a primary device (secondary mode) |
| busy_l_o | output | 1 | Busy toward left (primary mode), else 0 |
| r_cs_n | input | 1 | Right port select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read enable, active low |
| r_ub_n | input | 1 | Right upper lane enable, active low |
| r_lb_n | input | 1 | Right lower lane enable, active low |
| r_addr | input | 14 | Right address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data |
| busy_r_i | input | 1 | Busy toward right, from a primary device (secondary mode) |
| busy_r_o | output | 1 | Busy toward right (primary mode), else 0 |

## Verification
The bench targets four kinds of bug: who wins, whether the loser's write is kept out, whether that write survives, and lane masking.

For the winner, it has one port arrive a cycle before the other, has both arrive in the same cycle, and keeps a match going over several cycles. An arbiter that re-decides every cycle, or that ignores history, gives the grant to the wrong side or flips it partway through.

For the loser, it contests a write against a reader. A design that does not gate the write lets the reader see corrupted data. It then releases the winner while the loser keeps its write presented. A design that latches a one-shot reject loses that write.

Lane-partial writes and reads, the secondary-mode flag path, and a long run of random colliding traffic checked against a model catch masking errors and wrong flag values.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;
endpackage

// File: rtl/dpram_arb_resolver.sv
module dpram_arb_resolver
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              r_en,
    input  logic [ADDR_W-1:0] r_addr,
    output logic              busy_l,
    output logic              busy_r
);
    typedef struct packed {
        logic              l_vld;
        logic [ADDR_W-1:0] l_addr;
        logic              r_vld;
        logic [ADDR_W-1:0] r_addr;
        owner_e            win;
    } arb_state_t;

    arb_state_t st_d, st_q;
    logic       match;
    logic       l_was, r_was;
    owner_e     winner;

    always_comb begin
        match  = l_en && r_en && (l_addr == r_addr);
        l_was  = st_q.l_vld && (st_q.l_addr == l_addr);
        r_was  = st_q.r_vld && (st_q.r_addr == r_addr);
        if (!match)
            winner = OWN_NONE;
        else if (st_q.win != OWN_NONE)
            winner = st_q.win;
        else if (r_was && !l_was)
            winner = OWN_RIGHT;
        else
            winner = OWN_LEFT;

        st_d        = st_q;
        st_d.l_vld  = l_en;
        st_d.l_addr = l_addr;
        st_d.r_vld  = r_en;
        st_d.r_addr = r_addr;
        st_d.win    = winner;

        busy_l = rst_n && (winner == OWN_RIGHT);
        busy_r = rst_n && (winner == OWN_LEFT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '{l_vld: 1'b0, l_addr: '0, r_vld: 1'b0, r_addr: '0, win: OWN_NONE};
        else
            st_q <= st_d;
    end

    AST_GRANT_HELD_L: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_r && match) ##1 match |-> busy_r) else $error("left grant lost"); // R5
    AST_GRANT_HELD_R: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l && match) ##1 match |-> busy_l) else $error("right grant lost"); // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!busy_l && !busy_r)) else $error("busy during reset"); // R1
endmodule

// File: rtl/dpram_arb_store.sv
module dpram_arb_store #(
    parameter int AW     = 11,
    parameter int LANE_W = 8,
    parameter int LANES  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [AW-1:0]           l_addr,
    input  logic [LANES-1:0]        l_wr,
    input  logic [LANES*LANE_W-1:0] l_wdata,
    input  logic                    l_rd,
    input  logic [LANES-1:0]        l_rmask,
    output logic [LANES*LANE_W-1:0] l_rdata,
    input  logic [AW-1:0]           r_addr,
    input  logic [LANES-1:0]        r_wr,
    input  logic [LANES*LANE_W-1:0] r_wdata,
    input  logic                    r_rd,
    input  logic [LANES-1:0]        r_rmask,
    output logic [LANES*LANE_W-1:0] r_rdata
);
    localparam int DEPTH = 1 << AW;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] l_rd_d, l_rd_q, r_rd_d, r_rd_q;

        always_ff @(posedge clk) begin
            if (l_wr[k]) mem[l_addr] <= l_wdata[k*LANE_W +: LANE_W];
            if (r_wr[k]) mem[r_addr] <= r_wdata[k*LANE_W +: LANE_W];
        end

        always_comb begin
            l_rd_d = l_rd_q;
            r_rd_d = r_rd_q;
            if (l_rd) l_rd_d = l_rmask[k] ? mem[l_addr] : '0;
            if (r_rd) r_rd_d = r_rmask[k] ? mem[r_addr] : '0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                l_rd_q <= '0;
                r_rd_q <= '0;
            end else begin
                l_rd_q <= l_rd_d;
                r_rd_q <= r_rd_d;
            end
        end

        assign l_rdata[k*LANE_W +: LANE_W] = l_rd_q;
        assign r_rdata[k*LANE_W +: LANE_W] = r_rd_q;
    end
endmodule

// File: rtl/dpram_arb_top.sv
module dpram_arb_top #(
    parameter int ADDR_W   = 14,
    parameter int LANE_W   = 8,
    parameter int STORE_AW = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  primary,
    input  logic                  l_cs_n,
    input  logic                  l_we_n,
    input  logic                  l_oe_n,
    input  logic                  l_ub_n,
    input  logic                  l_lb_n,
    input  logic [ADDR_W-1:0]     l_addr,
    input  logic [2*LANE_W-1:0]   l_wdata,
    output logic [2*LANE_W-1:0]   l_rdata,
    input  logic                  busy_l_i,
    output logic                  busy_l_o,
    input  logic                  r_cs_n,
    input  logic                  r_we_n,
    input  logic                  r_oe_n,
    input  logic                  r_ub_n,
    input  logic                  r_lb_n,
    input  logic [ADDR_W-1:0]     r_addr,
    input  logic [2*LANE_W-1:0]   r_wdata,
    output logic [2*LANE_W-1:0]   r_rdata,
    input  logic                  busy_r_i,
    output logic                  busy_r_o
);
    localparam int LANES = 2;

    logic             arb_busy_l, arb_busy_r;
    logic             eff_busy_l, eff_busy_r;
    logic [LANES-1:0] l_mask, r_mask, l_wr, r_wr;
    logic             l_rd, r_rd;

    dpram_arb_resolver #(.ADDR_W(ADDR_W)) u_resolver (
        .clk    (clk),
        .rst_n  (rst_n),
        .l_en   (!l_cs_n),
        .l_addr (l_addr),
        .r_en   (!r_cs_n),
        .r_addr (r_addr),
        .busy_l (arb_busy_l),
        .busy_r (arb_busy_r)
    );

    always_comb begin
        eff_busy_l = primary ? arb_busy_l : busy_l_i;
        eff_busy_r = primary ? arb_busy_r : busy_r_i;
        busy_l_o   = primary && arb_busy_l;
        busy_r_o   = primary && arb_busy_r;
        l_mask     = {!l_ub_n, !l_lb_n};
        r_mask     = {!r_ub_n, !r_lb_n};
        l_wr       = (!l_cs_n && !l_we_n && !eff_busy_l) ? l_mask : '0;
        r_wr       = (!r_cs_n && !r_we_n && !eff_busy_r) ? r_mask : '0;
        l_rd       = !l_cs_n && l_we_n && !l_oe_n;
        r_rd       = !r_cs_n && r_we_n && !r_oe_n;
    end

    dpram_arb_store #(.AW(STORE_AW), .LANE_W(LANE_W), .LANES(LANES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .l_addr  (l_addr[STORE_AW-1:0]),
        .l_wr    (l_wr),
        .l_wdata (l_wdata),
        .l_rd    (l_rd),
        .l_rmask (l_mask),
        .l_rdata (l_rdata),
        .r_addr  (r_addr[STORE_AW-1:0]),
        .r_wr    (r_wr),
        .r_wdata (r_wdata),
        .r_rd    (r_rd),
        .r_rmask (r_mask),
        .r_rdata (r_rdata)
    );

    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_l_o && busy_r_o)) else $error("both ports busy"); // R4
    AST_BUSY_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_l_o || busy_r_o) |-> (!l_cs_n && !r_cs_n && (l_addr == r_addr)))
        else $error("busy without collision"); // R4
endmodule

// File: tb/dpram_arb_top_test.sv
module dpram_arb_top_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n, primary;
    logic        l_cs_n, l_we_n, l_oe_n, l_ub_n, l_lb_n, busy_l_i, busy_l_o;
    logic        r_cs_n, r_we_n, r_oe_n, r_ub_n, r_lb_n, busy_r_i, busy_r_o;
    logic [13:0] l_addr, r_addr;
    logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 1'b0;
    logic [15:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    dpram_arb_top uut (
        .clk(clk), .rst_n(rst_n), .primary(primary),
        .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_ub_n(l_ub_n), .l_lb_n(l_lb_n),
        .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata), .busy_l_i(busy_l_i), .busy_l_o(busy_l_o),
        .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_ub_n(r_ub_n), .r_lb_n(r_lb_n),
        .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata), .busy_r_i(busy_r_i), .busy_r_o(busy_r_o)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // cycle: advance to just after the next rising edge
    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    // kind: 0 idle, 1 read, 2 write
    task automatic drv_l(input int kind, input logic [13:0] a, input logic [15:0] d, input logic ub, input logic lb);
        l_cs_n = (kind == 0); l_we_n = (kind != 2); l_oe_n = (kind != 1);
        l_ub_n = ub; l_lb_n = lb; l_addr = a; l_wdata = d;
    endtask

    task automatic drv_r(input int kind, input logic [13:0] a, input logic [15:0] d, input logic ub, input logic lb);
        r_cs_n = (kind == 0); r_we_n = (kind != 2); r_oe_n = (kind != 1);
        r_ub_n = ub; r_lb_n = lb; r_addr = a; r_wdata = d;
    endtask

    task automatic idle();
        drv_l(0, 0, 0, 1, 1);
        drv_r(0, 0, 0, 1, 1);
    endtask

    task automatic rd_l_chk(input logic [13:0] a, input logic [15:0] exp, input string req);
        drv_l(1, a, 0, 0, 0);
        cyc();
        chk(req, "left read", l_rdata, exp);
        drv_l(0, 0, 0, 1, 1);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; primary = 1'b1; busy_l_i = 1'b0; busy_r_i = 1'b0;
        drv_l(1, 14'd5, 0, 0, 0);
        drv_r(1, 14'd5, 0, 0, 0);
        repeat (3) cyc();
        chk("R1", "busy_l in reset", busy_l_o, 0);
        chk("R1", "busy_r in reset", busy_r_o, 0);
        chk("R1", "l_rdata reset", l_rdata, 0);
        chk("R1", "r_rdata reset", r_rdata, 0);
        idle();
        rst_n = 1'b1;
        cyc();
    endtask

    task automatic t_lanes();
        drv_l(2, 14'd10, 16'hA5A5, 0, 0); cyc();
        drv_l(2, 14'd10, 16'h12FF, 0, 1); cyc();
        drv_l(0, 0, 0, 1, 1);
        drv_r(2, 14'd10, 16'hFF34, 1, 0); cyc();
        drv_r(1, 14'd10, 0, 0, 0); cyc();
        chk("R2", "lane writes merged", r_rdata, 16'h1234);
        drv_r(1, 14'd10, 0, 1, 0); cyc();
        chk("R3", "lower-only read", r_rdata, 16'h0034);
        drv_r(0, 0, 0, 1, 1); cyc();
        chk("R3", "read data holds", r_rdata, 16'h0034);
        // write then immediate read on the next edge
        drv_l(2, 14'd11, 16'h5A5A, 0, 0); cyc();
        drv_l(1, 14'd11, 0, 0, 0); cyc();
        chk("R3", "next-edge read", l_rdata, 16'h5A5A);
        idle(); cyc();
    endtask

    task automatic t_parallel();
        drv_l(2, 14'd12, 16'h0C0C, 0, 0);
        drv_r(2, 14'd13, 16'h0D0D, 0, 0);
        #1;
        chk("R11", "no busy on distinct addr", {busy_l_o, busy_r_o}, 0);
        cyc();
        drv_l(1, 14'd13, 0, 0, 0);
        drv_r(1, 14'd12, 0, 0, 0);
        cyc();
        chk("R11", "left wrote", r_rdata, 16'h0C0C);
        chk("R11", "right wrote", l_rdata, 16'h0D0D);
        idle(); cyc();
    endtask

    task automatic t_first_wins();
        drv_l(1, 14'd20, 0, 0, 0); #1;
        chk("R4", "single port no busy", {busy_l_o, busy_r_o}, 0);
        cyc();
        drv_r(1, 14'd20, 0, 0, 0); #1;
        chk("R5", "left earlier: busy_r", {busy_l_o, busy_r_o}, 2'b01);
        cyc(); #1;
        chk("R5", "left grant held", {busy_l_o, busy_r_o}, 2'b01);
        cyc(); #1;
        chk("R5", "left grant held 2", {busy_l_o, busy_r_o}, 2'b01);
        idle(); cyc();
        drv_r(1, 14'd21, 0, 0, 0); cyc();
        drv_l(1, 14'd21, 0, 0, 0); #1;
        chk("R5", "right earlier: busy_l", {busy_l_o, busy_r_o}, 2'b10);
        cyc(); #1;
        chk("R5", "right grant held", {busy_l_o, busy_r_o}, 2'b10);
        idle(); cyc();
    endtask

    task automatic t_tie();
        drv_l(1, 14'd30, 0, 0, 0);
        drv_r(1, 14'd30, 0, 0, 0); #1;
        chk("R6", "tie favours left", {busy_l_o, busy_r_o}, 2'b01);
        idle(); cyc();
    endtask

    task automatic t_block_and_hold();
        drv_l(2, 14'd40, 16'h1111, 0, 0); cyc();
        drv_l(1, 14'd40, 0, 0, 0); cyc();
        drv_r(2, 14'd40, 16'h2222, 0, 0); #1;
        chk("R4", "write collision busy_r", busy_r_o, 1);
        cyc(); // left read captured here, right write blocked
        chk("R7", "blocked write invisible", l_rdata, 16'h1111);
        cyc();
        chk("R7", "still blocked", l_rdata, 16'h1111);
        drv_l(0, 0, 0, 1, 1); #1;
        chk("R4", "busy cleared on deselect", busy_r_o, 0);
        cyc(); // held right write commits
        drv_r(0, 0, 0, 1, 1);
        rd_l_chk(14'd40, 16'h2222, "R8");
        cyc();
    endtask

    task automatic t_loser_read();
        drv_l(2, 14'd50, 16'hBEEF, 0, 0); cyc();
        drv_r(1, 14'd50, 0, 0, 0); #1;
        chk("R9", "reader is busy", busy_r_o, 1);
        cyc();
        chk("R9", "busy reader gets data", r_rdata, 16'hBEEF);
        drv_l(2, 14'd50, 16'hCAFE, 0, 0); cyc();
        cyc();
        chk("R9", "winner write seen next cycle", r_rdata, 16'hCAFE);
        idle(); cyc();
    endtask

    task automatic t_mismatch();
        drv_l(1, 14'd60, 0, 0, 0);
        drv_r(1, 14'd60, 0, 0, 0); cyc();
        drv_r(1, 14'd61, 0, 0, 0); #1;
        chk("R4", "busy drops on mismatch", {busy_l_o, busy_r_o}, 0);
        idle(); cyc();
    endtask

    task automatic t_secondary();
        drv_l(2, 14'd70, 16'h7070, 0, 0); cyc();
        drv_l(2, 14'd71, 16'h7171, 0, 0); cyc();
        primary = 1'b0;
        drv_l(1, 14'd72, 0, 0, 0);
        drv_r(1, 14'd72, 0, 0, 0); #1;
        chk("R10", "secondary busy outputs low", {busy_l_o, busy_r_o}, 0);
        busy_l_i = 1'b1;
        drv_r(0, 0, 0, 1, 1);
        drv_l(2, 14'd70, 16'hDEAD, 0, 0); cyc();
        busy_l_i = 1'b0;
        rd_l_chk(14'd70, 16'h7070, "R10");
        drv_l(2, 14'd70, 16'h0770, 0, 0); cyc();
        rd_l_chk(14'd70, 16'h0770, "R10");
        primary = 1'b1;
        busy_l_i = 1'b1;
        drv_l(2, 14'd71, 16'h1771, 0, 0); cyc();
        busy_l_i = 1'b0;
        rd_l_chk(14'd71, 16'h1771, "R10");
        cyc();
    endtask

    task automatic t_random();
        logic       lv, rv, le, re, lw, rw, ml, mr, lwas, rwas, bl, br;
        logic [1:0] la, ra, pla, pra, lm, rm;
        logic [15:0] ld, rd;
        int         win;
        for (int i = 0; i < 4; i++) begin
            drv_l(2, 14'd80 + 14'(i), 16'h0, 0, 0); cyc();
            model[i] = 16'h0;
        end
        idle(); cyc();
        lv = 0; rv = 0; pla = 0; pra = 0; win = 0;
        for (int n = 0; n < 400; n++) begin
            le = ($urandom_range(0, 3) != 0); re = ($urandom_range(0, 3) != 0);
            lw = $urandom_range(0, 1); rw = $urandom_range(0, 1);
            la = 2'($urandom_range(0, 3)); ra = 2'($urandom_range(0, 3));
            lm = 2'($urandom_range(0, 3)); rm = 2'($urandom_range(0, 3));
            ld = 16'($urandom); rd = 16'($urandom);
            drv_l(le ? (lw ? 2 : 1) : 0, 14'd80 + 14'(la), ld, ~lm[1], ~lm[0]);
            drv_r(re ? (rw ? 2 : 1) : 0, 14'd80 + 14'(ra), rd, ~rm[1], ~rm[0]);
            ml = le && re && (la == ra);
            lwas = lv && (pla == la);
            rwas = rv && (pra == ra);
            if (!ml) win = 0;
            else if (win == 0) win = (rwas && !lwas) ? 2 : 1;
            bl = (win == 2); br = (win == 1);
            #1;
            chk("R5", "random busy pair", {busy_l_o, busy_r_o}, {bl, br});
            if (le && lw && !bl) begin
                if (lm[1]) model[la][15:8] = ld[15:8];
                if (lm[0]) model[la][7:0]  = ld[7:0];
            end
            if (re && rw && !br) begin
                if (rm[1]) model[ra][15:8] = rd[15:8];
                if (rm[0]) model[ra][7:0]  = rd[7:0];
            end
            lv = le; rv = re; pla = la; pra = ra;
            cyc();
        end
        idle(); cyc();
        for (int i = 0; i < 4; i++) rd_l_chk(14'd80 + 14'(i), model[i], "R7");
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_lanes();
        t_parallel();
        t_first_wins();
        t_tie();
        t_block_and_hold();
        t_loser_read();
        t_mismatch();
        t_secondary();
        t_random();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule